// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front End

This block sits between a register bus and the bit-level engine of an I2C master. The host issues transfers through one data/command register: each write adds one entry to a transmit/command queue. Bit 8 of the write chooses the entry type. When bit 8 is set, the entry is a read request. When it is clear, the entry is a byte to send. Reads of the same register return bytes that the engine has pushed into a receive queue.

The host can read the fill level of each queue. It programs two thresholds. The first drives a "transmit queue running low" interrupt line. The second drives a "receive data waiting" interrupt line. A read-only word reports the depth of each queue. Three sticky error flags record a write to a full transmit queue, a read from an empty receive queue, and a byte lost because the receive queue was full. Writing 0 to the enable register empties both queues. While the block is disabled, the engine is offered no commands.

The register interface is one 3-bit word select, with one access per cycle. Read data is registered and appears the cycle after the read strobe.

Top module: `i2c_cmdq_frontend`

## Requirements
- R1: A write to select 0 with wdata bit 8 clear queues the command {0, wdata[7:0]}. The engine receives it on eng_cmd_data in order of arrival.
- R2: A write to select 0 with wdata bit 8 set queues a read command, which the engine sees as 9'h100. The low eight bits are discarded.
- R3: A read of select 0 removes the oldest receive byte and returns it on reg_rdata[7:0] one cycle after the strobe. Bytes come out in the order the engine pushed them.
- R4: Select 1 returns the number of entries in the transmit/command queue. Select 2 returns the number of bytes in the receive queue.
- R5: Select 7 returns the parameter word: transmit depth minus one in bits 23:16, receive depth minus one in bits 15:8, and zero in all other bits.
- R6: irq_tx_empty is high whenever the transmit level is less than or equal to the transmit threshold (select 3). After reset, both thresholds are 0.
- R7: irq_rx_full is high whenever the receive level is greater than the receive threshold (select 4). With a threshold of 0, it rises on the first byte.
- R8: A threshold write with a value above depth minus one stores depth minus one. The stored value reads back on the same select.
- R9: A data write to a full transmit queue is dropped and sets flag bit 0 (select 6). The level stays at the depth.
- R10: A data read from an empty receive queue returns 0 and sets flag bit 1.
- R11: An engine push to a full receive queue drops the byte and sets flag bit 2. The bytes already held are kept.
- R12: Writing 0 to bit 0 of select 5 empties both queues, so both levels read 0 afterwards.
- R13: eng_cmd_valid is high only while the enable bit (select 5, bit 0, reset 0) is 1 and the command queue is not empty. Writing 1s to select 6 clears the matching flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_cmd_valid | output | 1 | A command is offered to the engine |
| eng_cmd_data | output | 9 | Head command: bit 8 read request, bits 7:0 byte |
| eng_cmd_pop | input | 1 | Engine takes the head command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq_tx_empty | output | 1 | Transmit level at or below its threshold |
| irq_rx_full | output | 1 | Receive level above its threshold |

## Verification
The assertions assume that reset is held for at least one clock with every strobe low. They also assume the host never raises reg_wr and reg_rd in the same cycle, because the flag-cause checks rely on single-access cycles. The stimulus meets these assumptions. It drives every strobe from tasks that own the bus for exactly one cycle. The engine pop comes from a monitor that pulses it only while eng_cmd_valid is high.

// File: rtl/i2cq_pkg.sv
// Shared definitions for the I2C command/receive queue front end.
// Assumes a 3-bit word select on the register side.
package i2cq_pkg;
    typedef enum logic [2:0] {
        SEL_DATA   = 3'd0,
        SEL_TXLVL  = 3'd1,
        SEL_RXLVL  = 3'd2,
        SEL_TXTHR  = 3'd3,
        SEL_RXTHR  = 3'd4,
        SEL_ENABLE = 3'd5,
        SEL_FLAGS  = 3'd6,
        SEL_PARAM  = 3'd7
    } reg_sel_e;

    localparam int FLAG_TX_OVER  = 0;
    localparam int FLAG_RX_UNDER = 1;
    localparam int FLAG_RX_OVER  = 2;
    localparam int FLAG_W        = 3;
endpackage

// File: rtl/i2cq_fifo.sv
// Synchronous circular queue with a level counter and a flush input.
// A push while full or a pop while empty is ignored, and flush wins over both.
// Assumes DEPTH >= 1.
module i2cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    assert_pop_drops_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push && !flush) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/i2cq_thresh.sv
// Programmable threshold with write clamping and a level comparator.
// ABOVE=1 flags level > threshold; ABOVE=0 flags level <= threshold.
// Assumes the level never exceeds DEPTH.
module i2cq_thresh #(
    parameter int DEPTH = 8,
    parameter bit ABOVE = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [31:0]                  wr_value,
    input  logic [$clog2(DEPTH+1)-1:0]   level,
    output logic [$clog2(DEPTH+1)-1:0]   thr,
    output logic                         hit
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [31:0] MAXV = 32'(DEPTH - 1);

    // Threshold register, clamped to depth minus one on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     thr <= '0;
        else if (wr_en) thr <= (wr_value > MAXV) ? LW'(MAXV) : LW'(wr_value);
    end

    // Comparator direction picked by the ABOVE parameter.
    generate
        if (ABOVE) begin : g_above
            assign hit = (level > thr);
        end else begin : g_at_or_below
            assign hit = (level <= thr);
        end
    endgenerate

    assert_thr_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr <= LW'(MAXV));
endmodule

// File: rtl/i2c_cmdq_frontend.sv
// Register-side front end of an I2C master: a transmit/command queue filled by
// host writes, a receive queue filled by the engine, level and threshold
// registers, sticky error flags and a depth parameter word.
// Assumes at most one of reg_wr/reg_rd per cycle and depths of 1..256.
module i2c_cmdq_frontend
    import i2cq_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        eng_cmd_valid,
    output logic [8:0]  eng_cmd_data,
    input  logic        eng_cmd_pop,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        irq_tx_empty,
    output logic        irq_rx_full
);
    localparam int TLW = $clog2(TX_DEPTH + 1);
    localparam int RLW = $clog2(RX_DEPTH + 1);
    localparam logic [31:0] PARAM_WORD =
        {8'd0, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'd0};

    reg_sel_e          sel;
    logic              enable_q;
    logic [FLAG_W-1:0] flags_q;
    logic              flush;
    logic              wr_data, rd_data;
    logic [8:0]        tx_entry;
    logic [TLW-1:0]    tx_level, tx_thr;
    logic [RLW-1:0]    rx_level, rx_thr;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]        rx_head;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_data  = reg_wr && (sel == SEL_DATA);
    assign rd_data  = reg_rd && (sel == SEL_DATA);
    assign flush    = reg_wr && (sel == SEL_ENABLE) && !reg_wdata[0];
    assign tx_entry = reg_wdata[8] ? 9'h100 : {1'b0, reg_wdata[7:0]};

    i2cq_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(wr_data), .push_data(tx_entry),
        .pop(eng_cmd_pop && eng_cmd_valid),
        .head(eng_cmd_data), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_data), .head(rx_head), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    i2cq_thresh #(.DEPTH(TX_DEPTH), .ABOVE(1'b0)) u_txthr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && (sel == SEL_TXTHR)), .wr_value(reg_wdata),
        .level(tx_level), .thr(tx_thr), .hit(irq_tx_empty)
    );

    i2cq_thresh #(.DEPTH(RX_DEPTH), .ABOVE(1'b1)) u_rxthr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && (sel == SEL_RXTHR)), .wr_value(reg_wdata),
        .level(rx_level), .thr(rx_thr), .hit(irq_rx_full)
    );

    assign eng_cmd_valid = enable_q && !tx_empty;

    // Enable bit held from the last write to the enable select.
    always_ff @(posedge clk) begin
        if (!rst_n)                              enable_q <= 1'b0;
        else if (reg_wr && (sel == SEL_ENABLE)) enable_q <= reg_wdata[0];
    end

    // Sticky error flags: write-one-to-clear, with a new event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            logic [FLAG_W-1:0] nxt;
            nxt = flags_q;
            if (reg_wr && (sel == SEL_FLAGS)) nxt = nxt & ~reg_wdata[FLAG_W-1:0];
            if (wr_data && tx_full)     nxt[FLAG_TX_OVER]  = 1'b1;
            if (rd_data && rx_empty)    nxt[FLAG_RX_UNDER] = 1'b1;
            if (eng_rx_push && rx_full) nxt[FLAG_RX_OVER]  = 1'b1;
            flags_q <= nxt;
        end
    end

    // Registered read-data mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_DATA:   reg_rdata <= rx_empty ? 32'd0 : {24'd0, rx_head};
                SEL_TXLVL:  reg_rdata <= 32'(tx_level);
                SEL_RXLVL:  reg_rdata <= 32'(rx_level);
                SEL_TXTHR:  reg_rdata <= 32'(tx_thr);
                SEL_RXTHR:  reg_rdata <= 32'(rx_thr);
                SEL_ENABLE: reg_rdata <= {31'd0, enable_q};
                SEL_FLAGS:  reg_rdata <= 32'(flags_q);
                SEL_PARAM:  reg_rdata <= PARAM_WORD;
                default:    reg_rdata <= '0;
            endcase
        end
    end

    assert_tx_over_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FLAG_TX_OVER] && !$past(flags_q[FLAG_TX_OVER]))
            |-> $past(reg_wr && reg_addr == 3'd0 && tx_level == TLW'(TX_DEPTH)));
    assert_rx_under_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FLAG_RX_UNDER] && !$past(flags_q[FLAG_RX_UNDER]))
            |-> $past(reg_rd && reg_addr == 3'd0 && rx_level == '0));
    assert_rx_over_keeps_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_level == RLW'(RX_DEPTH) && !reg_rd && !reg_wr)
            |=> (rx_level == RLW'(RX_DEPTH)));
    assert_cmd_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |-> (enable_q && tx_level != '0));
    assert_irq_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> irq_tx_empty);
endmodule

// File: tb/i2c_cmdq_frontend_tb.sv
`timescale 1ns/1ps
module i2c_cmdq_frontend_tb_top;
    localparam int TXD = 8;
    localparam int RXD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_cmd_valid;
    logic [8:0]  eng_cmd_data;
    logic        eng_cmd_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        irq_tx_empty, irq_rx_full;

    int   total = 0;
    int   bad = 0;
    bit   drain_en = 1'b0;
    bit   finished = 1'b0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    i2c_cmdq_frontend #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_data(eng_cmd_data),
        .eng_cmd_pop(eng_cmd_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .irq_tx_empty(irq_tx_empty),
        .irq_rx_full(irq_rx_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: queue a command and record what the engine must see.
    task automatic send(input logic [31:0] d, input bit expect_kept);
        if (expect_kept) exp_q.push_back(d[8] ? 9'h100 : {1'b0, d[7:0]});
        wr(3'd0, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    // Monitor: act as the engine and compare each command taken (R1, R2).
    always @(negedge clk) begin
        if (drain_en && eng_cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected command", 32'(eng_cmd_data), 32'h1ff);
            end else begin
                chk("R1/R2 command order", 32'(eng_cmd_data), 32'(exp_q.pop_front()));
            end
            eng_cmd_pop = 1'b1;
        end else begin
            eng_cmd_pop = 1'b0;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(3'd1, v); chk("R4 reset tx level", v, 0);
        rd(3'd2, v); chk("R4 reset rx level", v, 0);
        rd(3'd6, v); chk("R13 reset flags", v, 0);
        chk("R6 reset irq_tx_empty", 32'(irq_tx_empty), 1);
        chk("R7 reset irq_rx_full", 32'(irq_rx_full), 0);
        chk("R13 reset cmd valid", 32'(eng_cmd_valid), 0);
        rd(3'd7, v); chk("R5 parameter word", v, 32'h0007_0700);

        // Mixed writes and reads queued, then drained
        wr(3'd5, 1);
        send(32'h0A5, 1'b1);
        send(32'h100, 1'b1);
        send(32'h13C, 1'b1);
        rd(3'd1, v); chk("R4 tx level 3", v, 3);
        chk("R6 level 3 above thr 0", 32'(irq_tx_empty), 0);
        wr(3'd3, 3);
        chk("R6 level 3 at thr 3", 32'(irq_tx_empty), 1);
        drain_en = 1'b1;
        repeat (8) @(negedge clk);
        drain_en = 1'b0;
        rd(3'd1, v); chk("R1 tx drained", v, 0);
        chk("R2 all commands seen", 32'(exp_q.size()), 0);

        // Threshold clamping
        wr(3'd3, 100); rd(3'd3, v); chk("R8 tx thr clamp", v, TXD - 1);
        wr(3'd4, 9);   rd(3'd4, v); chk("R8 rx thr clamp", v, RXD - 1);
        wr(3'd3, 0);
        wr(3'd4, 2);

        // Receive path and threshold
        rx_push(8'h11); rx_push(8'h22);
        chk("R7 level 2 not above 2", 32'(irq_rx_full), 0);
        rx_push(8'h33);
        chk("R7 level 3 above 2", 32'(irq_rx_full), 1);
        rd(3'd2, v); chk("R4 rx level 3", v, 3);
        rd(3'd0, v); chk("R3 first byte", v, 32'h11);
        chk("R7 after pop", 32'(irq_rx_full), 0);
        rd(3'd0, v); chk("R3 second byte", v, 32'h22);
        rd(3'd0, v); chk("R3 third byte", v, 32'h33);
        rd(3'd0, v); chk("R10 empty read data", v, 0);
        rd(3'd6, v); chk("R10 under flag", v, 32'h2);
        wr(3'd6, 32'h2);
        rd(3'd6, v); chk("R13 flag cleared", v, 0);

        // Transmit overflow
        for (int i = 0; i < TXD + 1; i++) send(32'h060 + 32'(i), 1'b0);
        rd(3'd1, v); chk("R9 tx level stays at depth", v, TXD);
        rd(3'd6, v); chk("R9 over flag", v, 32'h1);

        // Flush on disable
        wr(3'd5, 0);
        rd(3'd1, v); chk("R12 tx flushed", v, 0);
        wr(3'd6, 32'h7);

        // Receive overflow with threshold 0
        wr(3'd4, 0);
        rx_push(8'h40);
        chk("R7 thr 0 first byte", 32'(irq_rx_full), 1);
        for (int i = 1; i < RXD + 1; i++) rx_push(8'h40 + 8'(i));
        rd(3'd2, v); chk("R11 rx level at depth", v, RXD);
        rd(3'd6, v); chk("R11 rx over flag", v, 32'h4);
        for (int i = 0; i < RXD; i++) begin
            rd(3'd0, v); chk("R11 kept bytes", v, 32'h40 + 32'(i));
        end
        rx_push(8'h77);
        wr(3'd5, 0);
        rd(3'd2, v); chk("R12 rx flushed", v, 0);

        // Disabled block offers no command
        drain_en = 1'b1;
        send(32'h055, 1'b1);
        repeat (3) @(negedge clk);
        chk("R13 no valid while disabled", 32'(eng_cmd_valid), 0);
        rd(3'd1, v); chk("R13 command held", v, 1);
        wr(3'd5, 1);
        repeat (4) @(negedge clk);
        chk("R13 command taken once enabled", 32'(exp_q.size()), 0);
        drain_en = 1'b0;

        finish_run();
    end
endmodule